// File: doc/BRIEF.md
# Bit Clock Presence Detector

This block holds one 8-bit control/status register and the logic that tells firmware whether an external codec is driving a shared bit-clock pin. The raw bit-clock input passes through a two-flop synchronizer into the system clock domain. A counter then counts the edges of the synchronized signal. Once enough edges arrive while detection is enabled, an active-low detect flag in the register drops to 0.

Firmware works the detector through two bits: a clear bit, which holds the flag at its inactive value and restarts the count, and an enable bit, which lets the flag update. Removing enable freezes the flag at the value it holds. A mode bit picks the link signalling variant and sets the direction of the bit-clock pad. Only while the mode bit is 1 does the block drive the pin.

The mode bit is reset only by power-on reset. The other bits also return to their reset values on a warm reset.

Top module: `bclk_presence_det`

## Requirements
- R1: Bits 7:4 of the register always read 0, and writes to them have no effect.
- R2: After power-on reset the register reads 0x02 (mode 0, flag 1, enable 0, clear 0) and the pad output-enable is 0.
- R3: Bit 0 is the mode bit: 0 selects the legacy mode, with the pad undriven (bclk_oe = 0), and 1 selects the newer mode, with the pad driven (bclk_oe = 1).
- R4: While bit 3 (clear) holds 1, bit 1 reads 1 whatever the bit-clock does, even when bit 2 (enable) is also 1.
- R5: Bit 1 (detect flag, active low) is read-only: a write of 1 or 0 to it does not change it.
- R6: With bit 2 = 1, bit 3 = 0 and bit 0 = 0, bit 1 falls to 0 after 4 edges of the synchronized bit-clock. Bits 3, 2 and 0 read back the last value written to them.
- R7: While bit 2 = 0, bit 1 keeps its current value (0 or 1) whatever the bit-clock does, as long as clear stays 0.
- R8: A warm reset returns bits 3:1 to 0, 0, 1 and leaves bit 0 and the pad output-enable unchanged.
- R9: Three edges are not enough to declare toggling. Setting clear restarts the edge count from zero, so after clear is released exactly 4 new edges are needed.
- R10: While bit 0 = 1, detection is suspended and bit 1 holds its last value even with enable set and the input toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; resets every bit |
| rst_n | input | 1 | Warm reset, asynchronous, active low; spares the mode bit |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| bclk_in | input | 1 | Raw bit-clock from the pad, asynchronous to clk |
| bclk_oe | output | 1 | Pad output-enable for the bit-clock pin |

## Verification
The hardest state to reach is a flag that is already 0 and must stay 0 while the input keeps toggling, either because enable was removed or because the mode bit was set. A flag at 1 cannot tell freezing apart from a detector that does nothing. The stimulus first drives a real detection with four paced edges, then drops enable or sets the mode bit, and toggles again. The three-versus-four edge boundary is reached in the same way, right after a clear has been released, which also shows that the count restarts from zero.

// File: rtl/bcpd_pkg.sv
package bcpd_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_MODE = 0;
    localparam int BIT_FLAG = 1;
    localparam int BIT_EN   = 2;
    localparam int BIT_CLR  = 3;

    // Warm-reset domain of the register: clear, enable, detect flag
    typedef struct packed {
        logic clr;
        logic en;
        logic flag_n;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{clr: 1'b0, en: 1'b0, flag_n: 1'b1};

endpackage

// File: rtl/bcpd_sync.sv
module bcpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/bcpd_toggle_det.sv
module bcpd_toggle_det #(
    parameter int THRESH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic count_en,
    input  logic cnt_clr,
    output logic hit
);

    localparam int CNT_W = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       edge_seen;

    assign edge_seen = sync_in ^ st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
        if (cnt_clr) begin
            st_d.cnt = '0;
        end else if (count_en && edge_seen && (st_q.cnt != LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = (st_q.cnt == LIMIT);

endmodule

// File: rtl/bcpd_ctrl_regs.sv
module bcpd_ctrl_regs
    import bcpd_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hit,
    output logic             mode,
    output logic             det_active,
    output logic             cnt_clr,
    output logic [REG_W-1:0] rd_data
);

    ctrl_state_t st_d, st_q;
    logic        mode_d, mode_q;

    always_comb begin
        st_d   = st_q;
        mode_d = mode_q;
        // Flag update uses the settings currently held
        if (st_q.clr) begin
            st_d.flag_n = 1'b1;
        end else if (st_q.en && !mode_q && hit) begin
            st_d.flag_n = 1'b0;
        end
        if (wr_en) begin
            st_d.clr = wr_data[BIT_CLR];
            st_d.en  = wr_data[BIT_EN];
            mode_d   = wr_data[BIT_MODE];
        end
    end

    always_ff @(posedge clk or negedge warm_rst_n) begin
        if (!warm_rst_n) st_q <= CTRL_RESET;
        else             st_q <= st_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode_q <= 1'b0;
        else        mode_q <= mode_d;
    end

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_MODE] = mode_q;
        rd_data[BIT_FLAG] = st_q.flag_n;
        rd_data[BIT_EN]   = st_q.en;
        rd_data[BIT_CLR]  = st_q.clr;
    end

    assign mode       = mode_q;
    assign det_active = st_q.en && !st_q.clr && !mode_q;
    assign cnt_clr    = st_q.clr;

endmodule

// File: rtl/bclk_presence_det.sv
module bclk_presence_det
    import bcpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_THRESH = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             bclk_in,
    output logic             bclk_oe
);

    logic warm_rst_n;
    logic bclk_sync;
    logic hit;
    logic mode;
    logic det_active;
    logic cnt_clr;

    assign warm_rst_n = por_n & rst_n;

    bcpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (warm_rst_n),
        .async_in (bclk_in),
        .sync_out (bclk_sync)
    );

    bcpd_toggle_det #(.THRESH(EDGE_THRESH)) u_det (
        .clk      (clk),
        .rst_n    (warm_rst_n),
        .sync_in  (bclk_sync),
        .count_en (det_active),
        .cnt_clr  (cnt_clr),
        .hit      (hit)
    );

    bcpd_ctrl_regs u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .hit        (hit),
        .mode       (mode),
        .det_active (det_active),
        .cnt_clr    (cnt_clr),
        .rd_data    (rd_data)
    );

    assign bclk_oe = mode;

endmodule

// File: rtl/bcpd_checker.sv
module bcpd_checker (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic       bclk_oe
);

    // R1: reserved bits never read as 1
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[7:4] == 4'h0);

    // R3: pad is never driven in legacy mode
    a_r3_no_drive_legacy: assert property (@(posedge clk) disable iff (!por_n)
        !rd_data[0] |-> !bclk_oe);

    // R4: clear held one cycle forces the flag inactive
    a_r4_clear_forces_flag: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        rd_data[3] |=> rd_data[1]);

    // R7: flag frozen while enable is off and clear is off
    a_r7_frozen_when_disabled: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!rd_data[2] && !rd_data[3]) |=> $stable(rd_data[1]));

    // R10: flag frozen in the newer mode
    a_r10_frozen_in_mode: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (rd_data[0] && !rd_data[3]) |=> $stable(rd_data[1]));

    // R6: the flag only falls while detection was enabled
    a_r6_fall_needs_enable: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $fell(rd_data[1]) |-> $past(rd_data[2]));

endmodule

bind bclk_presence_det bcpd_checker u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (rst_n),
    .rd_data (rd_data),
    .bclk_oe (bclk_oe)
);

// File: tb/tb_bclk_presence_det.sv
`timescale 1ns/1ps
module tb_bclk_presence_det;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       bclk_in = 1'b0;
    logic       bclk_oe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bclk_presence_det dut (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .bclk_in (bclk_in),
        .bclk_oe (bclk_oe)
    );

    task automatic check_reg(input string req, input logic [7:0] exp_rd, input logic exp_oe);
        tests++;
        if (rd_data !== exp_rd || bclk_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s: rd_data=%02h oe=%0b expected rd_data=%02h oe=%0b",
                     req, rd_data, bclk_oe, exp_rd, exp_oe);
        end
    endtask

    task automatic reg_write(input logic [7:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic toggle_bclk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bclk_in = ~bclk_in;
            repeat (4) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (3) @(negedge clk);
        check_reg("R2 power-on state", 8'h02, 1'b0);
    endtask

    task automatic t_ignored_bits;
        reg_write(8'hF2);
        check_reg("R1 R5 reserved and flag writes ignored", 8'h02, 1'b0);
        reg_write(8'hF0);
        check_reg("R5 flag write of 0 ignored", 8'h02, 1'b0);
    endtask

    task automatic t_detect;
        reg_write(8'h04);
        check_reg("R6 enable reads back", 8'h06, 1'b0);
        toggle_bclk(4);
        check_reg("R6 four edges detected", 8'h04, 1'b0);
    endtask

    task automatic t_clear_and_boundary;
        reg_write(8'h0C);
        check_reg("R4 clear forces flag", 8'h0E, 1'b0);
        toggle_bclk(6);
        check_reg("R4 clear dominates enable", 8'h0E, 1'b0);
        reg_write(8'h04);
        toggle_bclk(3);
        check_reg("R9 three edges not enough", 8'h06, 1'b0);
        toggle_bclk(1);
        check_reg("R9 fourth edge after clear detects", 8'h04, 1'b0);
    endtask

    task automatic t_freeze;
        reg_write(8'h00);
        check_reg("R7 disable keeps flag 0", 8'h00, 1'b0);
        toggle_bclk(3);
        check_reg("R7 flag 0 frozen while toggling", 8'h00, 1'b0);
        reg_write(8'h08);
        check_reg("R4 clear with enable off", 8'h0A, 1'b0);
        reg_write(8'h00);
        toggle_bclk(6);
        check_reg("R7 flag 1 frozen while toggling", 8'h02, 1'b0);
    endtask

    task automatic t_mode;
        reg_write(8'h01);
        check_reg("R3 newer mode drives pad", 8'h03, 1'b1);
        reg_write(8'h05);
        toggle_bclk(6);
        check_reg("R10 no detection in newer mode", 8'h07, 1'b1);
    endtask

    task automatic t_warm_reset;
        reg_write(8'h0D);
        check_reg("R6 bits 3,2,0 read back", 8'h0F, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_reg("R8 warm reset keeps mode", 8'h03, 1'b1);
    endtask

    task automatic t_por_again;
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        repeat (2) @(negedge clk);
        check_reg("R2 power-on clears mode", 8'h02, 1'b0);
        reg_write(8'h00);
        check_reg("R3 legacy mode pad undriven", 8'h02, 1'b0);
    endtask

    initial begin
        t_reset();
        t_ignored_bits();
        t_detect();
        t_clear_and_boundary();
        t_freeze();
        t_mode();
        t_warm_reset();
        t_por_again();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule